// File: doc/BRIEF.md
# Audio Clock Master Generator

This block makes the frame clock and the bit clock for a stereo audio converter that acts as clock master. Both clocks come from a single master clock. After reset the two clock pins are read as configuration straps. The frame-clock pin picks single or double speed. The bit-clock pin picks between the power-of-two ratio family and the three-times ratio family. Each pin is modelled as a separate input, output and output-enable.

Once the straps are settled, the block counts master clock cycles over a fixed number of periods of a slow, already synchronized reference tick. From that count it picks the lower or the higher master-to-frame ratio of the selected family. It then enables both pins and starts the clocks with the frame clock in its left-channel phase. The bit clock always runs at 64 periods per frame. A half-rate sampling clock runs from reset release.

Top module: `aclk_master_gen`

## Requirements
- R1: While reset is held and until configuration completes, `lrck_oe_o` and `sclk_oe_o` are 0, `lrck_o` and `sclk_o` are 0, and `mclk_lrck_ratio_o` is 0 during reset.
- R2: A strap pair is accepted only after `STRAP_SAMPLES` consecutive master clock samples agree. A strap that changes every 2 cycles never completes configuration. Strap changes after acceptance have no effect on the status outputs.
- R3: `lrck_pin_i` = 0 selects single speed (`dbl_speed_o` = 0); `lrck_pin_i` = 1 selects double speed (`dbl_speed_o` = 1).
- R4: `sclk_pin_i` = 0 selects the power-of-two family (`fam3x_o` = 0) and `sclk_pin_i` = 1 selects the 3x family (`fam3x_o` = 1). `mclk_lrck_ratio_o` is: single speed 256/512 or 384/768; double speed 128/256 or 192/384 (low/high).
- R5: The measured value is the number of master clock cycles spanning `WINDOW_TICKS` reference tick periods. `ratio_hi_o` = 1 only when this count is strictly greater than (`EXP_LO_CNT`+`EXP_HI_CNT`)/2. Equality selects the low ratio.
- R6: The bit clock period is ratio/64 master cycles (d). Each period starts with ceil(d/2) low cycles followed by floor(d/2) high cycles, and the bit clock never rises while the outputs are disabled.
- R7: `lrck_o` toggles every 32 bit clock periods, only at the start of a bit clock period, giving a frame of exactly ratio master cycles.
- R8: The cycle after the output enables rise, both clocks are low (left channel) and the first bit clock period begins.
- R9: `mod_clk_o` toggles on every master clock edge after reset release.
- R10: The output enables rise only after both strap acceptance and frequency measurement have finished, and they stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low reset, synchronous to mclk_i |
| ref_tick_i | input | 1 | One-cycle reference pulse, synchronous to mclk_i |
| lrck_pin_i | input | 1 | Frame-clock pin input (speed strap) |
| sclk_pin_i | input | 1 | Bit-clock pin input (ratio family strap) |
| lrck_o | output | 1 | Frame clock, 0 = left channel |
| lrck_oe_o | output | 1 | Frame-clock pin output enable |
| sclk_o | output | 1 | Bit clock |
| sclk_oe_o | output | 1 | Bit-clock pin output enable |
| mod_clk_o | output | 1 | Half-rate sampling clock |
| dbl_speed_o | output | 1 | Accepted speed selection |
| fam3x_o | output | 1 | Accepted ratio family |
| ratio_hi_o | output | 1 | Measured high-ratio selection |
| mclk_lrck_ratio_o | output | 10 | Active master-to-frame ratio, 0 until running |

## Verification
A wrong divide factor or a wrong low/high duty split shows in the bit clock within one period of d master cycles after the enables rise. A wrong bit counter moves the first frame-clock toggle away from cycle 32·d. A bad measurement decision or a bad strap latch shows on the status outputs in the same cycle the enables rise. It also distorts the clock periods right after. Enables that come too early show as pins driven while the straps are still toggling.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    typedef enum logic [1:0] {
        PH_STRAP   = 2'd0,
        PH_MEASURE = 2'd1,
        PH_RUN     = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        MT_IDLE  = 2'd0,
        MT_ARM   = 2'd1,
        MT_COUNT = 2'd2,
        MT_DONE  = 2'd3
    } meter_e;

    // Master cycles per bit clock period for a given configuration.
    function automatic logic [3:0] sclk_div(input logic dbl, input logic f3, input logic hi);
        logic [3:0] d;
        d = f3 ? 4'd3 : 4'd2;
        if (!dbl) d = d << 1;
        if (hi)   d = d << 1;
        return d;
    endfunction

    // Master cycles per frame = 64 bit periods.
    function automatic logic [9:0] frame_ratio(input logic dbl, input logic f3, input logic hi);
        return {sclk_div(dbl, f3, hi), 6'b000000};
    endfunction

endpackage

// File: rtl/aclk_strap_sampler.sv
module aclk_strap_sampler #(
    parameter int N_SAMPLES = 4,
    parameter int WIDTH     = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] pins_i,
    output logic             done_o,
    output logic [WIDTH-1:0] val_o
);
    localparam int CW = $clog2(N_SAMPLES + 1);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [CW-1:0]    cnt;
        logic             done;
        logic [WIDTH-1:0] val;
    } strap_t;

    strap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            if (st_q.cnt == '0 || pins_i != st_q.prev) begin
                st_d.prev = pins_i;
                st_d.cnt  = CW'(1);
            end else if (st_q.cnt == CW'(N_SAMPLES - 1)) begin
                st_d.done = 1'b1;
                st_d.val  = pins_i;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign val_o  = st_q.val;

    // R2
    strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.done && $past(st_q.done)) |-> $stable(st_q.val));

    // R2
    strap_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CW'(N_SAMPLES - 1));

endmodule

// File: rtl/aclk_mclk_meter.sv
module aclk_mclk_meter
    import aclk_pkg::*;
#(
    parameter int WINDOW_TICKS = 2,
    parameter int EXP_LO_CNT   = 32,
    parameter int EXP_HI_CNT   = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic tick_i,
    output logic done_o,
    output logic hi_o
);
    localparam int MID     = (EXP_LO_CNT + EXP_HI_CNT) / 2;
    localparam int CNT_MAX = EXP_HI_CNT * 2;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int TW      = $clog2(WINDOW_TICKS + 1);

    typedef struct packed {
        meter_e        st;
        logic [CW-1:0] cnt;
        logic [TW-1:0] tk;
        logic          hi;
    } meter_t;

    meter_t m_d, m_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = (m_q.cnt == CW'(CNT_MAX)) ? m_q.cnt : m_q.cnt + CW'(1);
        m_d     = m_q;
        case (m_q.st)
            MT_IDLE: if (start_i) m_d.st = MT_ARM;
            MT_ARM: begin
                if (tick_i) begin
                    m_d.cnt = '0;
                    m_d.tk  = '0;
                    m_d.st  = MT_COUNT;
                end
            end
            MT_COUNT: begin
                m_d.cnt = cnt_inc;
                if (tick_i) begin
                    if (m_q.tk == TW'(WINDOW_TICKS - 1)) begin
                        m_d.hi = (cnt_inc > CW'(MID));
                        m_d.st = MT_DONE;
                    end else begin
                        m_d.tk = m_q.tk + TW'(1);
                    end
                end
            end
            default: m_d = m_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) m_q <= '{st: MT_IDLE, cnt: '0, tk: '0, hi: 1'b0};
        else         m_q <= m_d;
    end

    assign done_o = (m_q.st == MT_DONE);
    assign hi_o   = m_q.hi;

    // R5
    meter_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_q.st == MT_DONE && $past(m_q.st == MT_DONE)) |-> $stable(m_q.hi));

    // R5
    meter_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_q.cnt <= CW'(CNT_MAX));

endmodule

// File: rtl/aclk_clk_gen.sv
module aclk_clk_gen #(
    parameter int BITS_PER_HALF = 32
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic [3:0] div_i,
    output logic       sclk_o,
    output logic       lrck_o
);
    localparam int BW = $clog2(BITS_PER_HALF);

    typedef struct packed {
        logic [3:0]    cnt;
        logic [BW-1:0] bitn;
        logic          sclk;
        logic          lrck;
    } gen_t;

    gen_t g_d, g_q;
    logic [3:0] low_len;
    logic       wrap;

    always_comb begin
        low_len = div_i - (div_i >> 1);
        wrap    = (g_q.cnt == div_i - 4'd1);
        g_d     = g_q;
        if (!run_i) begin
            g_d = '0;
        end else begin
            g_d.cnt  = wrap ? 4'd0 : g_q.cnt + 4'd1;
            g_d.sclk = (g_d.cnt >= low_len);
            if (wrap) begin
                if (g_q.bitn == BW'(BITS_PER_HALF - 1)) begin
                    g_d.bitn = '0;
                    g_d.lrck = ~g_q.lrck;
                end else begin
                    g_d.bitn = g_q.bitn + BW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) g_q <= '0;
        else         g_q <= g_d;
    end

    assign sclk_o = g_q.sclk;
    assign lrck_o = g_q.lrck;

    // R7
    lrck_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (g_q.lrck != $past(g_q.lrck)) |-> (g_q.cnt == 4'd0 && !g_q.sclk));

    // R6
    sclk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(g_q.sclk) |-> $past(run_i));

    // R6
    div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (div_i >= 4'd2));

endmodule

// File: rtl/aclk_master_gen.sv
module aclk_master_gen
    import aclk_pkg::*;
#(
    parameter int STRAP_SAMPLES = 4,
    parameter int WINDOW_TICKS  = 2,
    parameter int EXP_LO_CNT    = 32,
    parameter int EXP_HI_CNT    = 64
) (
    input  logic       mclk_i,
    input  logic       rst_ni,
    input  logic       ref_tick_i,
    input  logic       lrck_pin_i,
    input  logic       sclk_pin_i,
    output logic       lrck_o,
    output logic       lrck_oe_o,
    output logic       sclk_o,
    output logic       sclk_oe_o,
    output logic       mod_clk_o,
    output logic       dbl_speed_o,
    output logic       fam3x_o,
    output logic       ratio_hi_o,
    output logic [9:0] mclk_lrck_ratio_o
);
    typedef struct packed {
        phase_e ph;
        logic   oe;
        logic   mod;
    } top_t;

    top_t t_d, t_q;

    logic       strap_done, meas_done, meas_hi;
    logic [1:0] strap_val;
    logic [3:0] div;

    aclk_strap_sampler #(
        .N_SAMPLES (STRAP_SAMPLES),
        .WIDTH     (2)
    ) u_strap (
        .clk_i  (mclk_i),
        .rst_ni (rst_ni),
        .pins_i ({lrck_pin_i, sclk_pin_i}),
        .done_o (strap_done),
        .val_o  (strap_val)
    );

    aclk_mclk_meter #(
        .WINDOW_TICKS (WINDOW_TICKS),
        .EXP_LO_CNT   (EXP_LO_CNT),
        .EXP_HI_CNT   (EXP_HI_CNT)
    ) u_meter (
        .clk_i   (mclk_i),
        .rst_ni  (rst_ni),
        .start_i (strap_done),
        .tick_i  (ref_tick_i),
        .done_o  (meas_done),
        .hi_o    (meas_hi)
    );

    assign div = sclk_div(strap_val[1], strap_val[0], meas_hi);

    aclk_clk_gen #(
        .BITS_PER_HALF (32)
    ) u_gen (
        .clk_i  (mclk_i),
        .rst_ni (rst_ni),
        .run_i  (t_q.oe),
        .div_i  (div),
        .sclk_o (sclk_o),
        .lrck_o (lrck_o)
    );

    always_comb begin
        t_d     = t_q;
        t_d.mod = ~t_q.mod;
        case (t_q.ph)
            PH_STRAP:   if (strap_done) t_d.ph = PH_MEASURE;
            PH_MEASURE: begin
                if (meas_done) begin
                    t_d.ph = PH_RUN;
                    t_d.oe = 1'b1;
                end
            end
            default:    t_d.ph = PH_RUN;
        endcase
    end

    always_ff @(posedge mclk_i) begin
        if (!rst_ni) t_q <= '{ph: PH_STRAP, oe: 1'b0, mod: 1'b0};
        else         t_q <= t_d;
    end

    assign lrck_oe_o         = t_q.oe;
    assign sclk_oe_o         = t_q.oe;
    assign mod_clk_o         = t_q.mod;
    assign dbl_speed_o       = strap_val[1];
    assign fam3x_o           = strap_val[0];
    assign ratio_hi_o        = meas_hi;
    assign mclk_lrck_ratio_o = t_q.oe ? frame_ratio(strap_val[1], strap_val[0], meas_hi) : 10'd0;

    // R10
    oe_needs_cfg_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        sclk_oe_o |-> (strap_done && meas_done));

    // R10
    oe_sticky_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        $past(sclk_oe_o) |-> sclk_oe_o);

    // R9
    mod_toggle_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (mod_clk_o != $past(mod_clk_o)));

    // R1
    pins_quiet_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        !lrck_oe_o |-> (!lrck_o && !sclk_o));

endmodule

// File: tb/tb_aclk_master_gen.sv
module tb_aclk_master_gen;
    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick;
    logic       lrck_pin = 1'b0;
    logic       sclk_pin = 1'b0;
    logic       lrck, lrck_oe, sclk, sclk_oe, mod_clk;
    logic       dbl, f3, hi;
    logic [9:0] ratio;

    int checks = 0;
    int errors = 0;
    int tick_per = 16;
    int tcnt = 0;

    aclk_master_gen dut (
        .mclk_i            (mclk),
        .rst_ni            (rst_n),
        .ref_tick_i        (ref_tick),
        .lrck_pin_i        (lrck_pin),
        .sclk_pin_i        (sclk_pin),
        .lrck_o            (lrck),
        .lrck_oe_o         (lrck_oe),
        .sclk_o            (sclk),
        .sclk_oe_o         (sclk_oe),
        .mod_clk_o         (mod_clk),
        .dbl_speed_o       (dbl),
        .fam3x_o           (f3),
        .ratio_hi_o        (hi),
        .mclk_lrck_ratio_o (ratio)
    );

    initial forever #10 mclk = ~mclk;

    initial begin
        ref_tick = 1'b0;
        forever begin
            @(negedge mclk);
            tcnt++;
            if (tcnt >= tick_per) begin
                ref_tick = 1'b1;
                tcnt = 0;
            end else begin
                ref_tick = 1'b0;
            end
        end
    end

    initial begin
        repeat (180000) @(posedge mclk);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit ds, input bit fam, input int per);
        rst_n = 1'b0;
        lrck_pin = ds;
        sclk_pin = fam;
        tick_per = per;
        repeat (3) @(negedge mclk);
        rst_n = 1'b1;
    endtask

    // Waits for the enables; returns quiet=1 when pins stayed low meanwhile.
    task automatic wait_oe(output bit quiet, output bit seen);
        quiet = 1'b1;
        seen  = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge mclk);
            if (sclk_oe && lrck_oe) seen = 1'b1;
            else if (sclk || lrck || sclk_oe || lrck_oe) quiet = 1'b0;
        end
    endtask

    task automatic run_case(input bit ds, input bit fam, input int per);
        bit quiet, seen, exp_hi;
        int exp_ratio, d, lowl, bad_s, bad_l, first_bad, act_s, exp_s;
        exp_hi    = (2 * per) > 48;
        exp_ratio = (fam ? 192 : 128) << (ds ? 0 : 1) << (exp_hi ? 1 : 0);
        d         = exp_ratio / 64;
        lowl      = d - d / 2;
        do_reset(ds, fam, per);
        wait_oe(quiet, seen);
        chk(seen && quiet, "R1/R10 enables low until configured", int'(quiet), 1);
        chk(dbl == ds, "R3 speed strap", int'(dbl), int'(ds));
        chk(f3 == fam, "R4 family strap", int'(f3), int'(fam));
        chk(hi == exp_hi, "R5 ratio decision", int'(hi), int'(exp_hi));
        chk(int'(ratio) == exp_ratio, "R4 ratio value", int'(ratio), exp_ratio);
        chk(!sclk && !lrck, "R8 start phase", int'({lrck, sclk}), 0);
        lrck_pin = ~ds;
        sclk_pin = ~fam;
        bad_s = 0; bad_l = 0; first_bad = -1; act_s = 0; exp_s = 0;
        for (int n = 0; n < 128 * d; n++) begin
            if (n > 0) @(negedge mclk);
            if (int'(sclk) != int'((n % d) >= lowl) || !sclk_oe) begin
                if (bad_s == 0) begin
                    first_bad = n;
                    act_s = int'(sclk);
                    exp_s = int'((n % d) >= lowl);
                end
                bad_s++;
            end
            if (int'(lrck) != ((n / (32 * d)) % 2) || !lrck_oe) bad_l++;
        end
        if (bad_s != 0)
            $display("  sclk first mismatch at offset %0d: actual=%0d expected=%0d", first_bad, act_s, exp_s);
        chk(bad_s == 0, "R6 bit clock waveform mismatches", bad_s, 0);
        chk(bad_l == 0, "R7 frame clock waveform mismatches", bad_l, 0);
        chk(dbl == ds && f3 == fam && int'(ratio) == exp_ratio,
            "R2 strap change after acceptance ignored", int'(ratio), exp_ratio);
    endtask

    initial begin
        bit quiet, seen;
        int bad;
        // Reset state
        repeat (2) @(negedge mclk);
        chk(!lrck_oe && !sclk_oe && !sclk && !lrck && ratio == 10'd0,
            "R1 reset state", int'({lrck_oe, sclk_oe, sclk, lrck}), 0);
        rst_n = 1'b1;
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge mclk);
            if (mod_clk != ((i % 2) == 0)) bad++;
        end
        chk(bad == 0, "R9 half-rate sampling clock", bad, 0);

        // Sweep all strap combinations at a low and a high master rate
        for (int s = 0; s < 4; s++) begin
            run_case(s[1], s[0], 16);
            run_case(s[1], s[0], 32);
        end
        // Decision boundary: count 48 equals midpoint, 50 is above
        run_case(1'b0, 1'b1, 24);
        run_case(1'b1, 1'b0, 25);

        // Strap that never settles keeps the pins quiet
        do_reset(1'b0, 1'b0, 16);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            lrck_pin = i[1];
            @(negedge mclk);
            if (lrck_oe || sclk_oe || lrck || sclk) bad++;
        end
        chk(bad == 0, "R2 toggling strap never accepted", bad, 0);
        lrck_pin = 1'b1;
        wait_oe(quiet, seen);
        chk(seen && dbl == 1'b1, "R2 settled strap accepted", int'(dbl), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule